// File: doc/BRIEF.md
# Single-Wire Bus Reset Detector and Presence Responder

This block sits on the slave side of a single-wire, open-drain, bit-serial bus. It samples the shared data line with a known-frequency clock and measures every interval during which the line is held low. When such an interval is long enough to count as a bus reset, the block emits a one-cycle reset strobe. After the master releases the line, the block waits a fixed time and then pulls the line low for a fixed time through an open-drain enable. That low pulse tells the master that a slave is present.

Two timing sets exist: a regular set and a faster overdrive set. An input selects between them. A reset low that reaches the regular-speed minimum also raises a second strobe. The surrounding logic uses that strobe to leave overdrive, and presence for that reset then uses regular timing. Bit slots and command decoding belong to other blocks.

Top module: `swire_reset_presence`

## Requirements
- R1: After `rst_n` is deasserted, `rst_det_o`, `long_rst_o` and `pres_drv_o` are all 0, and they stay 0 while the line stays high.
- R2: With `od_mode_i`=0, a low interval of at least RST_REG_US microseconds raises `rst_det_o` and `long_rst_o` together. This happens on the third clock edge after the raw line returns high: two edges for the synchronizer and one for the output register.
- R3: With `od_mode_i`=0, a low interval shorter than RST_REG_US microseconds raises no strobe and starts no presence.
- R4: With `od_mode_i`=1, a low interval of at least RST_OD_US and below RST_REG_US microseconds raises `rst_det_o` with `long_rst_o` left at 0.
- R5: With `od_mode_i`=1, a low interval of at least RST_REG_US microseconds raises both strobes, and the presence that follows uses regular timing.
- R6: With `od_mode_i`=1, a low interval shorter than RST_OD_US microseconds raises no strobe.
- R7: After a reset at regular timing, `pres_drv_o` rises exactly WAIT_REG_US×CYC_PER_US cycles after the `rst_det_o` cycle and stays high for exactly LOW_REG_US×CYC_PER_US cycles.
- R8: After a reset at overdrive timing, the wait is WAIT_OD_US×CYC_PER_US cycles and the drive lasts LOW_OD_US×CYC_PER_US cycles.
- R9: A falling edge on the line during the wait cancels that presence. The new low interval is measured from that edge, and a qualifying new reset starts a fresh presence.
- R10: While `pres_drv_o` is high, the line level is ignored. Any low the master adds during the drive produces no strobe.
- R11: Each strobe lasts exactly one clock cycle per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, CYC_PER_US cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw sampled level of the bus line |
| od_mode_i | input | 1 | 1 selects overdrive timing |
| rst_det_o | output | 1 | One-cycle strobe for each detected bus reset |
| long_rst_o | output | 1 | One-cycle strobe for a reset long enough to force regular speed |
| pres_drv_o | output | 1 | Open-drain enable; 1 pulls the line low for presence |

## Verification
A low-length counter that is off by one, or a wrong threshold, changes whether a strobe appears at the cycle three edges after release. The bench reports this within one clock. A wrong phase or timer value in the presence sequencer moves the edges of `pres_drv_o`. The bench compares every cycle, so a shift of a single cycle in the wait or the drive is reported at that edge. A stale speed choice after a long overdrive reset shows up as a drive that is 32 cycles long instead of 240.

// File: rtl/swire_reset_presence.sv
module swire_reset_presence #(
  parameter int CYC_PER_US  = 50,
  parameter int RST_REG_US  = 480,
  parameter int RST_OD_US   = 48,
  parameter int WAIT_REG_US = 30,
  parameter int LOW_REG_US  = 120,
  parameter int WAIT_OD_US  = 4,
  parameter int LOW_OD_US   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic od_mode_i,
  output logic rst_det_o,
  output logic long_rst_o,
  output logic pres_drv_o
);
  localparam int RST_REG_C  = CYC_PER_US * RST_REG_US;
  localparam int RST_OD_C   = CYC_PER_US * RST_OD_US;
  localparam int WAIT_REG_C = CYC_PER_US * WAIT_REG_US;
  localparam int LOW_REG_C  = CYC_PER_US * LOW_REG_US;
  localparam int WAIT_OD_C  = CYC_PER_US * WAIT_OD_US;
  localparam int LOW_OD_C   = CYC_PER_US * LOW_OD_US;
  localparam int MAXT_A     = (WAIT_REG_C > LOW_REG_C) ? WAIT_REG_C : LOW_REG_C;
  localparam int MAXT_B     = (WAIT_OD_C > LOW_OD_C) ? WAIT_OD_C : LOW_OD_C;
  localparam int MAXT       = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B;
  localparam int CW         = $clog2(RST_REG_C + 1);
  localparam int TW         = $clog2(MAXT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DRIVE} phase_t;

  logic          s1, s2;
  logic [CW-1:0] lo_cnt;
  logic [TW-1:0] tmr;
  logic          fast_q;
  phase_t        ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end

  wire rise    = s2 && (lo_cnt != '0) && (ph != S_DRIVE);
  wire meets   = lo_cnt >= (od_mode_i ? CW'(RST_OD_C) : CW'(RST_REG_C));
  wire longr   = lo_cnt >= CW'(RST_REG_C);
  wire hit     = rise && meets;
  wire go_fast = od_mode_i && !longr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       lo_cnt <= '0;
    else if (ph == S_DRIVE || s2)     lo_cnt <= '0;
    else if (lo_cnt != CW'(RST_REG_C)) lo_cnt <= lo_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_det_o  <= 1'b0;
      long_rst_o <= 1'b0;
    end else begin
      rst_det_o  <= hit;
      long_rst_o <= hit && longr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph     <= S_IDLE;
      tmr    <= '0;
      fast_q <= 1'b0;
    end else begin
      case (ph)
        S_IDLE:
          if (hit) begin
            ph     <= S_WAIT;
            fast_q <= go_fast;
            tmr    <= go_fast ? TW'(WAIT_OD_C - 1) : TW'(WAIT_REG_C - 1);
          end
        S_WAIT:
          if (!s2)
            ph <= S_IDLE;
          else if (tmr == '0) begin
            ph  <= S_DRIVE;
            tmr <= fast_q ? TW'(LOW_OD_C - 1) : TW'(LOW_REG_C - 1);
          end else
            tmr <= tmr - 1'b1;
        S_DRIVE:
          if (tmr == '0) ph <= S_IDLE;
          else           tmr <= tmr - 1'b1;
        default: ph <= S_IDLE;
      endcase
    end

  assign pres_drv_o = (ph == S_DRIVE);

  logic [TW:0] drv_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          drv_run <= '0;
    else if (pres_drv_o) drv_run <= drv_run + 1'b1;
    else                 drv_run <= '0;

  assert_long_has_det_R5: assert property (@(posedge clk) disable iff (!rst_n)
    long_rst_o |-> rst_det_o);
  assert_reg_reset_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_det_o && !$past(od_mode_i)) |-> long_rst_o);
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det_o |=> !rst_det_o);
  assert_quiet_in_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pres_drv_o |-> !rst_det_o);
  assert_wait_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det_o |=> !pres_drv_o);
  assert_drive_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_run <= (TW+1)'(MAXT));
endmodule

// File: tb/swire_reset_presence_bench.sv
module swire_reset_presence_bench;
  localparam int CPU = 2;
  localparam int RREG = 480 * CPU, ROD = 48 * CPU;
  localparam int WREG = 30 * CPU, LREG = 120 * CPU, WOD = 4 * CPU, LOD = 16 * CPU;

  logic clk = 0, rst_n = 0, m_low = 0, od = 0;
  logic det, lng, drv;
  wire  line = ~(m_low | drv);
  always #2 clk = ~clk;

  swire_reset_presence #(.CYC_PER_US(CPU)) u_swire_reset_presence (
    .clk(clk), .rst_n(rst_n), .line_i(line), .od_mode_i(od),
    .rst_det_o(det), .long_rst_o(lng), .pres_drv_o(drv));

  int compared = 0, mismatched = 0;
  int d1 = 1, d2 = 1, lowlen = 0, ph = 0, cnt = 0;
  bit fastm = 0, e_det = 0, e_lng = 0, e_drv = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1 = 1; d2 = 1; lowlen = 0; ph = 0; cnt = 0; e_det = 0; e_lng = 0;
    end else begin
      int seen, oldph; bit r, l;
      seen = d2; d2 = d1; d1 = line; oldph = ph;
      r = seen && lowlen > 0 && oldph != 2 && lowlen >= (od ? ROD : RREG);
      l = r && lowlen >= RREG;
      e_det = r; e_lng = l;
      if (oldph == 0 && r) begin
        ph = 1; fastm = od && !l; cnt = fastm ? WOD : WREG;
      end else if (oldph == 1) begin
        if (!seen) ph = 0;
        else begin cnt--; if (cnt == 0) begin ph = 2; cnt = fastm ? LOD : LREG; end end
      end else if (oldph == 2) begin
        cnt--; if (cnt == 0) ph = 0;
      end
      if (oldph == 2 || seen) lowlen = 0;
      else if (lowlen < RREG) lowlen++;
    end
    e_drv = (ph == 2);
  end

  int cyc = 0, n_det = 0, n_lng = 0, n_runs = 0, det_t = 0, gap = 0, cur = 0, last_len = 0, wide = 0;
  bit pdrv = 0, pdet = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      compared += 3;
      if (det !== e_det) begin mismatched++; $display("FAIL R2 rst_det_o cyc %0d act %b exp %b", cyc, det, e_det); end
      if (lng !== e_lng) begin mismatched++; $display("FAIL R5 long_rst_o cyc %0d act %b exp %b", cyc, lng, e_lng); end
      if (drv !== e_drv) begin mismatched++; $display("FAIL R7 pres_drv_o cyc %0d act %b exp %b", cyc, drv, e_drv); end
      if (det) begin n_det++; det_t = cyc; if (pdet) wide++; end
      if (lng) n_lng++;
      if (drv && !pdrv) begin n_runs++; gap = cyc - det_t; end
      if (drv) cur++;
      if (!drv && pdrv) begin last_len = cur; cur = 0; end
      pdrv = drv; pdet = det;
    end
    if (cyc > 150000) begin
      mismatched++; $display("FAIL watchdog act %0d exp <150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin mismatched++; $display("FAIL %s act %0d exp %0d", req, act, exp); end
  endtask

  task automatic low_for(int n);
    @(negedge clk) m_low = 1;
    repeat (n) @(negedge clk);
    m_low = 0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int b_det, b_lng, b_runs;
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle(20);
    chk(!det && !lng && !drv, "R1 idle outputs", {det, lng, drv}, 0);

    b_det = n_det; b_lng = n_lng;
    low_for(RREG + 40); settle(700);
    chk(n_det - b_det == 1 && n_lng - b_lng == 1, "R2 regular long reset", n_det - b_det, 1);
    chk(gap == WREG, "R7 regular wait", gap, WREG);
    chk(last_len == LREG, "R7 regular drive", last_len, LREG);

    b_det = n_det;
    low_for(RREG - 40); settle(400);
    chk(n_det == b_det, "R3 short regular low", n_det - b_det, 0);

    od = 1; b_det = n_det; b_lng = n_lng;
    low_for(ROD + 20); settle(200);
    chk(n_det - b_det == 1 && n_lng == b_lng, "R4 overdrive reset", n_lng - b_lng, 0);
    chk(gap == WOD, "R8 overdrive wait", gap, WOD);
    chk(last_len == LOD, "R8 overdrive drive", last_len, LOD);

    b_det = n_det;
    low_for(ROD - 20); settle(200);
    chk(n_det == b_det, "R6 short overdrive low", n_det - b_det, 0);

    b_det = n_det; b_lng = n_lng;
    low_for(RREG + 10); settle(700);
    chk(n_lng - b_lng == 1 && n_det - b_det == 1, "R5 long reset in overdrive", n_lng - b_lng, 1);
    chk(last_len == LREG && gap == WREG, "R5 regular presence after long", last_len, LREG);
    od = 0;

    b_det = n_det; b_runs = n_runs;
    low_for(RREG + 10); settle(20);
    chk(!drv, "R9 still waiting", drv, 0);
    low_for(RREG + 20); settle(700);
    chk(n_det - b_det == 2, "R9 two resets", n_det - b_det, 2);
    chk(n_runs - b_runs == 1, "R9 cancelled presence", n_runs - b_runs, 1);

    b_det = n_det;
    low_for(RREG + 10);
    while (!drv) @(negedge clk);
    settle(20); low_for(100); settle(600);
    chk(n_det - b_det == 1, "R10 line ignored in drive", n_det - b_det, 1);
    chk(last_len == LREG, "R10 drive length kept", last_len, LREG);

    chk(wide == 0, "R11 strobe width", wide, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule